// File: doc/BRIEF.md
# Asymmetric Decode Slot Allocator

This block steers instructions from a small fetch window into three decode slots that differ in capability. Each instruction arrives already classified by the number of internal operations it expands into. Slot 0 is the wide slot and accepts an instruction of up to four operations. The remaining slots are narrow and accept only single-operation instructions. Each cycle the block takes the longest program-order prefix of the window that fits this slot shape. It reports which slots were filled, how many instructions it consumed, and how many operations leave toward the back end.

An instruction too large for the wide slot is handed to a sequencer. The sequencer looks up the instruction's operation count in a small internal table and emits the operations a few per cycle. While it runs, the instruction window is held off. Both the window input and the operation output use a valid/ready handshake.

Top module: `decode_slot_steer`

## Requirements
- R1: The operation-count field of an instruction is 3 bits wide. Codes 1 to 4 mean direct decode with that many operations, and code 7 means sequencer decode. Codes 0, 5 and 6 are never presented.
- R2: On an accepted window whose first entry is a direct code, `slot_use` bit 0 is set. Window entry k always maps to slot k, and bit 0 is the wide slot.
- R3: For k of 1 or more, `slot_use` bit k is set only if bit k-1 is set, k is less than `in_cnt`, and entry k has code 1. Entries at or beyond `in_cnt` never change any output.
- R4: Three instructions are taken in one cycle only when `in_cnt` is 3 and both later entries have code 1. A later entry with any other code, including code 7, is not consumed in that cycle.
- R5: On a direct group, `take_cnt` equals the number of set `slot_use` bits. `op_cnt` equals the first entry's code plus `take_cnt` minus 1, with `op_from_rom` low.
- R6: A first entry with code 7 is consumed alone. `take_cnt` is 1, `slot_use` is 0, and `op_from_rom` is high.
- R7: The sequencer length is ROM_MIN + (opcode mod ROM_SPAN), which is 5 + (opcode mod 8) by default. Operations leave at up to ROM_RATE (4) per accepted beat. `op_step` gives the index of the first operation in the beat, and `op_opc` holds the latched opcode.
- R8: While operations of a sequenced instruction remain after the current beat, `rom_busy` is high, `in_ready` is low and `take_cnt` is 0. `rom_busy` falls after the final beat is accepted.
- R9: While `op_ready` is low, `in_ready` is low, nothing is consumed, and the sequencer position does not change.
- R10: A synchronous active-high reset clears the sequencer, so `rom_busy` is low and `in_ready` follows `op_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Window valid |
| in_ready | output | 1 | Window accepted this cycle when high together with in_valid |
| in_cnt | input | 2 | Number of occupied window entries (1 to 3) |
| in_opc | input | 24 | Opcodes, entry k in bits [8k+7:8k] |
| in_nops | input | 9 | Operation-count codes, entry k in bits [3k+2:3k] |
| op_ready | input | 1 | Back end accepts operations |
| op_valid | output | 1 | Operations offered this cycle |
| op_cnt | output | 3 | Number of operations in the beat |
| op_from_rom | output | 1 | Beat comes from the sequencer |
| op_opc | output | 8 | Opcode of the instruction producing the beat |
| op_step | output | 4 | Sequencer index of the first operation in the beat |
| take_cnt | output | 2 | Instructions consumed this cycle |
| slot_use | output | 3 | Slots filled this cycle, bit k for entry k |
| rom_busy | output | 1 | Sequencer has operations left |

## Verification
The assertions assume that every valid window has `in_cnt` between 1 and 3. They also assume that every occupied entry carries one of the legal codes 1 to 4 or 7. The bench only ever presents such windows, sweeping every legal code in every entry for each `in_cnt`, and it fills unoccupied entries with legal codes as well. It holds `in_valid` high while the sequencer runs, and it throttles `op_ready` on a fixed pattern, so stalls stay within the handshake rules.

// File: rtl/dss_pkg.sv
package dss_pkg;
   localparam int NOPS_W = 3;
   localparam logic [NOPS_W-1:0] NOPS_SEQ = 3'd7;

   function automatic logic nops_legal(input logic [NOPS_W-1:0] code, input int cx_max);
      return (code == NOPS_SEQ) || ((code != '0) && (int'(code) <= cx_max));
   endfunction
endpackage

// File: rtl/dss_group_pick.sv
module dss_group_pick
   import dss_pkg::*;
#(
   parameter int N_SLOT = 3,
   parameter int CNT_W  = 2,
   parameter int OPS_W  = 3
) (
   input  logic [CNT_W-1:0]         win_cnt,
   input  logic [N_SLOT*NOPS_W-1:0] win_nops,
   output logic [N_SLOT-1:0]        grp_use,
   output logic [CNT_W-1:0]         grp_take,
   output logic [OPS_W-1:0]         grp_ops,
   output logic                     grp_seq
);
   logic [NOPS_W-1:0] head_code;
   logic              head_ok;

   assign head_code = win_nops[NOPS_W-1:0];
   assign head_ok   = (win_cnt != '0);
   assign grp_seq   = head_ok && (head_code == NOPS_SEQ);
   assign grp_use[0] = head_ok && !grp_seq;

   for (genvar k = 1; k < N_SLOT; k++) begin : g_narrow
      assign grp_use[k] = grp_use[k-1] && (win_cnt > CNT_W'(k)) &&
                          (win_nops[k*NOPS_W +: NOPS_W] == NOPS_W'(1));
   end

   always_comb begin
      logic [CNT_W-1:0] n;
      n = '0;
      for (int i = 0; i < N_SLOT; i++) n = n + CNT_W'(grp_use[i]);
      grp_take = grp_seq ? CNT_W'(1) : n;
      grp_ops  = grp_use[0] ? (OPS_W'(head_code) + OPS_W'(n) - OPS_W'(1)) : '0;
   end
endmodule

// File: rtl/dss_rom_seq.sv
module dss_rom_seq #(
   parameter int OPC_W    = 8,
   parameter int LEN_W    = 4,
   parameter int ROM_MIN  = 5,
   parameter int ROM_SPAN = 8,
   parameter int ROM_RATE = 4,
   parameter int LEN_MODE = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [OPC_W-1:0] start_opc,
   input  logic             advance,
   output logic [LEN_W-1:0] first_cnt,
   output logic             busy,
   output logic [LEN_W-1:0] cur_cnt,
   output logic [LEN_W-1:0] cur_step,
   output logic [OPC_W-1:0] cur_opc
);
   logic [LEN_W-1:0] start_len;
   logic [LEN_W-1:0] rem_q, pos_q;
   logic [OPC_W-1:0] opc_q;

   if (LEN_MODE == 0) begin : g_len_mod
      assign start_len = LEN_W'(ROM_MIN) + LEN_W'(start_opc % OPC_W'(ROM_SPAN));
   end else begin : g_len_fixed
      assign start_len = LEN_W'(ROM_MIN);
   end

   assign first_cnt = (start_len > LEN_W'(ROM_RATE)) ? LEN_W'(ROM_RATE) : start_len;
   assign busy      = (rem_q != '0);
   assign cur_cnt   = (rem_q > LEN_W'(ROM_RATE)) ? LEN_W'(ROM_RATE) : rem_q;
   assign cur_step  = pos_q;
   assign cur_opc   = opc_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         rem_q <= '0;
         pos_q <= '0;
         opc_q <= '0;
      end else if (start) begin
         rem_q <= start_len - first_cnt;
         pos_q <= first_cnt;
         opc_q <= start_opc;
      end else if (busy && advance) begin
         rem_q <= rem_q - cur_cnt;
         pos_q <= pos_q + cur_cnt;
      end
   end

   // R8
   no_start_busy_chk: assert property (@(posedge clk) disable iff (rst) busy |-> !start);
   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && !advance && !start) |=> ($stable(rem_q) && $stable(pos_q)));
   // R7
   beat_bound_chk: assert property (@(posedge clk) disable iff (rst)
      busy |-> (cur_cnt != '0 && cur_cnt <= LEN_W'(ROM_RATE)));
endmodule

// File: rtl/decode_slot_steer.sv
module decode_slot_steer
   import dss_pkg::*;
#(
   parameter int OPC_W    = 8,
   parameter int N_NARROW = 2,
   parameter int CX_MAX   = 4,
   parameter int ROM_MIN  = 5,
   parameter int ROM_SPAN = 8,
   parameter int ROM_RATE = 4,
   parameter int LEN_MODE = 0,
   localparam int N_SLOT  = 1 + N_NARROW,
   localparam int CNT_W   = $clog2(N_SLOT + 1),
   localparam int PEAK    = (CX_MAX + N_NARROW > ROM_RATE) ? CX_MAX + N_NARROW : ROM_RATE,
   localparam int OPS_W   = $clog2(PEAK + 1),
   localparam int LEN_W   = $clog2(ROM_MIN + ROM_SPAN + 1)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   output logic                     in_ready,
   input  logic [CNT_W-1:0]         in_cnt,
   input  logic [N_SLOT*OPC_W-1:0]  in_opc,
   input  logic [N_SLOT*NOPS_W-1:0] in_nops,
   input  logic                     op_ready,
   output logic                     op_valid,
   output logic [OPS_W-1:0]         op_cnt,
   output logic                     op_from_rom,
   output logic [OPC_W-1:0]         op_opc,
   output logic [LEN_W-1:0]         op_step,
   output logic [CNT_W-1:0]         take_cnt,
   output logic [N_SLOT-1:0]        slot_use,
   output logic                     rom_busy
);
   if (CX_MAX < 1 || CX_MAX > 6) begin : g_bad_cx
      $error("CX_MAX must lie in 1..6");
   end
   if (ROM_MIN <= CX_MAX || ROM_MIN < 3) begin : g_bad_min
      $error("ROM_MIN must exceed CX_MAX and 2");
   end
   if (N_NARROW < 1 || ROM_RATE < 1 || ROM_SPAN < 1) begin : g_bad_cfg
      $error("N_NARROW, ROM_RATE and ROM_SPAN must be positive");
   end

   logic [N_SLOT-1:0] p_use;
   logic [CNT_W-1:0]  p_take;
   logic [OPS_W-1:0]  p_ops;
   logic              p_seq;
   logic              fire_in;
   logic [LEN_W-1:0]  s_first, s_cnt, s_step;
   logic [OPC_W-1:0]  s_opc;

   dss_group_pick #(.N_SLOT(N_SLOT), .CNT_W(CNT_W), .OPS_W(OPS_W)) u_pick (
      .win_cnt (in_cnt),
      .win_nops(in_nops),
      .grp_use (p_use),
      .grp_take(p_take),
      .grp_ops (p_ops),
      .grp_seq (p_seq)
   );

   assign in_ready = !rom_busy && op_ready;
   assign fire_in  = in_valid && in_ready;

   dss_rom_seq #(
      .OPC_W(OPC_W), .LEN_W(LEN_W), .ROM_MIN(ROM_MIN), .ROM_SPAN(ROM_SPAN),
      .ROM_RATE(ROM_RATE), .LEN_MODE(LEN_MODE)
   ) u_seq (
      .clk      (clk),
      .rst      (rst),
      .start    (fire_in && p_seq),
      .start_opc(in_opc[OPC_W-1:0]),
      .advance  (op_ready),
      .first_cnt(s_first),
      .busy     (rom_busy),
      .cur_cnt  (s_cnt),
      .cur_step (s_step),
      .cur_opc  (s_opc)
   );

   assign take_cnt = fire_in ? p_take : '0;
   assign slot_use = fire_in ? p_use : '0;
   assign op_valid = rom_busy || in_valid;

   always_comb begin
      if (rom_busy) begin
         op_cnt      = OPS_W'(s_cnt);
         op_from_rom = 1'b1;
         op_opc      = s_opc;
         op_step     = s_step;
      end else if (p_seq) begin
         op_cnt      = OPS_W'(s_first);
         op_from_rom = 1'b1;
         op_opc      = in_opc[OPC_W-1:0];
         op_step     = '0;
      end else begin
         op_cnt      = p_ops;
         op_from_rom = 1'b0;
         op_opc      = in_opc[OPC_W-1:0];
         op_step     = '0;
      end
   end

   // R1 (input assumption)
   legal_code_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> (in_cnt != '0 && int'(in_cnt) <= N_SLOT && nops_legal(in_nops[NOPS_W-1:0], CX_MAX)));
   // R8
   busy_block_chk: assert property (@(posedge clk) disable iff (rst)
      rom_busy |-> (!in_ready && take_cnt == '0));
   // R9
   stall_take_chk: assert property (@(posedge clk) disable iff (rst)
      !op_ready |-> (take_cnt == '0 && slot_use == '0));
   // R3
   contig_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(slot_use) == 0 || (slot_use[0] && $countones(slot_use) == int'(take_cnt)));
   // R6
   seq_alone_chk: assert property (@(posedge clk) disable iff (rst)
      (fire_in && op_from_rom) |-> (take_cnt == CNT_W'(1) && slot_use == '0));
   // R8
   seq_runs_chk: assert property (@(posedge clk) disable iff (rst)
      (fire_in && op_from_rom) |=> rom_busy);
endmodule

// File: tb/decode_slot_steer_bench.sv
module decode_slot_steer_bench;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid, in_ready, op_ready, op_valid, op_from_rom, rom_busy;
   logic [1:0]  in_cnt, take_cnt;
   logic [23:0] in_opc;
   logic [8:0]  in_nops;
   logic [2:0]  op_cnt, slot_use;
   logic [7:0]  op_opc;
   logic [3:0]  op_step;
   int          checks = 0;
   int          failures = 0;

   always #5 clk = ~clk;

   decode_slot_steer u_decode_slot_steer (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_cnt(in_cnt), .in_opc(in_opc), .in_nops(in_nops), .op_ready(op_ready),
      .op_valid(op_valid), .op_cnt(op_cnt), .op_from_rom(op_from_rom),
      .op_opc(op_opc), .op_step(op_step), .take_cnt(take_cnt),
      .slot_use(slot_use), .rom_busy(rom_busy)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [2:0] code_of(input int i);
      case (i)
         0: return 3'd1;
         1: return 3'd2;
         2: return 3'd3;
         3: return 3'd4;
         default: return 3'd7;
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int iter = 0;
      rst = 1'b1; in_valid = 1'b0; op_ready = 1'b1;
      in_cnt = 2'd1; in_opc = '0; in_nops = 9'o111;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      #1;
      check("R10 busy after reset", rom_busy, 0);
      check("R10 ready after reset", in_ready, 1);
      check("R10 take idle", take_cnt, 0);

      for (int c = 1; c <= 3; c++)
         for (int a = 0; a < 5; a++)
            for (int b = 0; b < 5; b++)
               for (int d = 0; d < 5; d++) begin
                  logic [2:0] n0, n1, n2;
                  logic [7:0] opc0;
                  int u1, u2, take, len, rem, pos, beat;
                  n0 = code_of(a); n1 = code_of(b); n2 = code_of(d);
                  opc0 = 8'((iter * 37 + 11) & 255);
                  iter++;
                  @(negedge clk);
                  in_valid = 1'b1; in_cnt = 2'(c);
                  in_nops = {n2, n1, n0};
                  in_opc = {8'(iter), 8'(iter + 3), opc0};
                  if (iter % 7 == 0) begin
                     op_ready = 1'b0;
                     #1;
                     check("R9 stall ready", in_ready, 0);
                     check("R9 stall take", take_cnt, 0);
                     check("R9 stall valid", op_valid, 1);
                     @(negedge clk);
                  end
                  op_ready = 1'b1;
                  #1;
                  if (n0 != 3'd7) begin
                     u1 = (c > 1 && n1 == 3'd1) ? 1 : 0;
                     u2 = (u1 == 1 && c > 2 && n2 == 3'd1) ? 1 : 0;
                     take = 1 + u1 + u2;
                     check("R2 R3 R4 slot_use", slot_use, 1 + 2 * u1 + 4 * u2);
                     check("R5 take", take_cnt, take);
                     check("R5 op_cnt", op_cnt, int'(n0) + take - 1);
                     check("R5 direct source", op_from_rom, 0);
                  end else begin
                     len = 5 + opc0 % 8;
                     check("R6 take", take_cnt, 1);
                     check("R6 slot_use", slot_use, 0);
                     check("R6 source", op_from_rom, 1);
                     check("R7 first beat", op_cnt, 4);
                     check("R7 first step", op_step, 0);
                     rem = len - 4; pos = 4; beat = 0;
                     while (rem > 0) begin
                        @(negedge clk);
                        in_opc[7:0] = ~opc0;
                        op_ready = (beat % 3 != 2);
                        beat++;
                        #1;
                        check("R8 busy", rom_busy, 1);
                        check("R8 ready low", in_ready, 0);
                        check("R8 no take", take_cnt, 0);
                        check("R7 beat cnt", op_cnt, rem > 4 ? 4 : rem);
                        check("R7 beat step", op_step, pos);
                        check("R7 latched opc", op_opc, opc0);
                        if (op_ready) begin
                           pos += (rem > 4 ? 4 : rem);
                           rem -= (rem > 4 ? 4 : rem);
                        end
                     end
                     @(negedge clk);
                     in_valid = 1'b0; op_ready = 1'b1;
                     #1;
                     check("R8 busy cleared", rom_busy, 0);
                  end
               end

      @(negedge clk);
      in_valid = 1'b1; in_cnt = 2'd1; in_nops = 9'o777; in_opc = 24'h000003;
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      check("R8 busy before reset", rom_busy, 1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      check("R10 busy cleared by reset", rom_busy, 0);
      check("R10 ready after mid reset", in_ready, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule